// File: doc/BRIEF.md
# Amplifier Offset Trim Calibrator

This block trims out the input offset of an on-chip amplifier by searching over a 7-bit trim code. The most significant trim bit selects the side of the correction (the direction bit). The six bits below it give the size of the correction (the magnitude bits). A single-cycle start pulse loads a starting code and raises a calibrate-enable output that routes the amplifier to its reference. The block then measures the amplifier through an external ADC controller. Each measurement follows a settling wait, counted in system clocks. The block latches the converted word and chooses its next action from the top three bits of that word alone.

The search takes one magnitude bit per pass, from bit 5 down to bit 0. A mode input, sampled at start, picks one of two starting points. In set mode the magnitude starts at all zeros and each pass raises one bit. In clear mode the magnitude starts at all ones and each pass drops one bit. After every measurement, the top three result bits together with the direction bit decide the next action. The block can keep the change and go on, undo the change and go on, or stop. When the search ends, the block drops calibrate-enable, pulses done and keeps the trim code until the next start.

Top module: `amp_trim_cal`

## Requirements
- R1: A start pulse accepted while idle loads direction 1 into the trim code. It loads magnitude 000000 in set mode (mode 0, trim 0x40) or 111111 in clear mode (mode 1, trim 0x7F), and it raises busy and calibrate-enable.
- R2: A conversion request is a single-cycle pulse, issued only while calibrate-enable is high. It is issued only after the trim code has stayed unchanged for at least SETTLE_CYC clocks.
- R3: A result word is judged only while a conversion is awaited. Its three most significant bits classify it: 111 is high, 000 is low, and any other pattern is mixed. The thresholds are exact, so 895 is mixed and 896 is high, 127 is low and 128 is mixed.
- R4: On the first measurement, a low result clears the direction bit, a high result leaves it at 1, and a mixed result ends calibration with the start code. The direction bit never rises during calibration.
- R5: Each pass changes one magnitude bit, starting at bit 5 and moving down to bit 0. Set mode writes the bit to 1 and clear mode writes it to 0. Every change is followed by a settling wait and a new measurement.
- R6: After a pass, a high result with direction 1 or a low result with direction 0 keeps the change and moves to the next bit. A low result with direction 1 or a high result with direction 0 puts the bit just changed back to its earlier value, then moves to the next bit. A mixed result ends calibration.
- R7: The search ends after the pass on bit 0, so one calibration makes at most seven conversions.
- R8: At the end, done is high for exactly one cycle with calibrate-enable already low. Busy falls in the next cycle, and the trim code then holds until the next accepted start.
- R9: A start pulse seen while busy is ignored, and so is any change on the mode input at that time. The calibration in progress keeps its code sequence and its number of conversions.
- R10: After reset, trim is 0x40 and busy, done, calibrate-enable and the conversion request are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 1 | 0 = set mode, 1 = clear mode, sampled at start |
| conv_done_i | input | 1 | ADC controller reports a finished conversion |
| conv_data_i | input | RES_W | Converted word, valid with conv_done_i |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when calibration ends |
| cal_en_o | output | 1 | Calibrate-enable, amplifier routed to its reference |
| conv_req_o | output | 1 | One-cycle request for a conversion |
| trim_o | output | 7 | Trim code: bit 6 direction, bits 5..0 magnitude |

## Verification
The hardest paths to reach from the ports are the undo path and the direction flip. Both depend on the measured word moving in response to the trim code the block has just written. The bench therefore models the amplifier as an offset plus a term proportional to the signed trim value, and it answers every request with the word for the trim code present at that moment. Chosen offsets force a low first result (which flips the direction), an overshoot right after bit 5 (which triggers an undo), a run that continues through several bits, and exact hits on both classification edges.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

    localparam int MAG_W   = 6;
    localparam int TRIM_W  = MAG_W + 1;
    localparam int JUDGE_W = 3;
    localparam int IDX_W   = $clog2(MAG_W);
    localparam int PASS_W  = $clog2(MAG_W + 1);

    typedef struct packed {
        logic             dir;
        logic [MAG_W-1:0] mag;
    } trim_t;

    typedef enum logic [1:0] {
        CLS_MIXED = 2'd0,
        CLS_LOW   = 2'd1,
        CLS_HIGH  = 2'd2
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT,
        ST_EVAL,
        ST_STEP,
        ST_UNDO,
        ST_FINISH
    } state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_DIR_LOW,
        OP_WRITE
    } trim_op_e;

    function automatic trim_t start_code(input logic clear_mode);
        trim_t t;
        t.dir = 1'b1;
        t.mag = clear_mode ? {MAG_W{1'b1}} : {MAG_W{1'b0}};
        return t;
    endfunction

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
    parameter int SETTLE_CYC = 52500
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/trim_result_judge.sv
module trim_result_judge
    import trim_cal_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [RES_W-1:0] data,
    output cls_e             cls
);
    localparam logic [RES_W-1:0] LOW_LIM  = RES_W'(1) << (RES_W - JUDGE_W);
    localparam logic [RES_W-1:0] HIGH_LIM = ~(LOW_LIM - RES_W'(1));

    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (capture) begin
            res_q <= data;
        end
    end

    always_comb begin
        if (res_q >= HIGH_LIM) begin
            cls = CLS_HIGH;
        end else if (res_q < LOW_LIM) begin
            cls = CLS_LOW;
        end else begin
            cls = CLS_MIXED;
        end
    end

endmodule

// File: rtl/trim_code_reg.sv
module trim_code_reg
    import trim_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  trim_op_e         op,
    input  logic             load_mode,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output trim_t            trim_q
);
    trim_t load_val;
    trim_t trim_d;

    assign load_val = start_code(load_mode);

    assign trim_d.dir = (op == OP_LOAD)    ? load_val.dir :
                        (op == OP_DIR_LOW) ? 1'b0 : trim_q.dir;

    for (genvar i = 0; i < MAG_W; i++) begin : g_mag
        assign trim_d.mag[i] =
            (op == OP_LOAD)                                   ? load_val.mag[i] :
            ((op == OP_WRITE) && (bit_idx == IDX_W'(i)))      ? bit_val :
                                                                trim_q.mag[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= start_code(1'b0);
        end else begin
            trim_q <= trim_d;
        end
    end

endmodule

// File: rtl/amp_trim_cal.sv
module amp_trim_cal
    import trim_cal_pkg::*;
#(
    parameter int SETTLE_CYC = 52500,
    parameter int RES_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             cal_en_o,
    output logic             conv_req_o,
    output logic [6:0]       trim_o
);
    state_e            state_q, state_d;
    logic [PASS_W-1:0] pass_q;
    logic              first_q;
    logic              mode_q;

    trim_op_e          op;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_val;
    logic              restart;
    logic              capture;
    logic              expired;
    cls_e              cls;
    trim_t             trim_q;
    logic              keep_step;

    trim_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .expired (expired)
    );

    trim_result_judge #(.RES_W(RES_W)) u_judge (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .data    (conv_data_i),
        .cls     (cls)
    );

    trim_code_reg u_code (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_mode (mode_i),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .trim_q    (trim_q)
    );

    assign keep_step = ((cls == CLS_HIGH) && trim_q.dir) ||
                       ((cls == CLS_LOW) && !trim_q.dir);

    always_comb begin
        state_d = state_q;
        op      = OP_HOLD;
        bit_idx = '0;
        bit_val = 1'b0;
        restart = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    op      = OP_LOAD;
                    restart = 1'b1;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (expired) state_d = ST_REQ;
            end
            ST_REQ: state_d = ST_WAIT;
            ST_WAIT: begin
                if (conv_done_i) begin
                    capture = 1'b1;
                    state_d = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (cls == CLS_MIXED) begin
                    state_d = ST_FINISH;
                end else if (first_q) begin
                    if (cls == CLS_LOW) op = OP_DIR_LOW;
                    state_d = ST_STEP;
                end else if (keep_step) begin
                    state_d = ST_STEP;
                end else begin
                    state_d = ST_UNDO;
                end
            end
            ST_STEP: begin
                if (pass_q == PASS_W'(MAG_W)) begin
                    state_d = ST_FINISH;
                end else begin
                    op      = OP_WRITE;
                    bit_idx = IDX_W'(MAG_W - 1 - int'(pass_q));
                    bit_val = !mode_q;
                    restart = 1'b1;
                    state_d = ST_SETTLE;
                end
            end
            ST_UNDO: begin
                op      = OP_WRITE;
                bit_idx = IDX_W'(MAG_W - int'(pass_q));
                bit_val = mode_q;
                state_d = ST_STEP;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            first_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                pass_q  <= '0;
                first_q <= 1'b1;
                mode_q  <= mode_i;
            end else begin
                if (state_q == ST_EVAL) first_q <= 1'b0;
                if (state_q == ST_STEP && pass_q != PASS_W'(MAG_W)) pass_q <= pass_q + 1'b1;
            end
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = (state_q == ST_FINISH);
    assign cal_en_o   = busy_o && !done_o;
    assign conv_req_o = (state_q == ST_REQ);
    assign trim_o     = trim_q;

endmodule

// File: rtl/amp_trim_cal_chk.sv
module amp_trim_cal_chk #(
    parameter int SETTLE_CYC = 52500
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       cal_en_o,
    input logic       conv_req_o,
    input logic [6:0] trim_o
);
    localparam int QW = $clog2(SETTLE_CYC + 2);
    localparam logic [QW-1:0] QMAX = QW'(SETTLE_CYC);

    logic [QW-1:0] quiet_q;
    logic [6:0]    prev_trim_q;
    logic          prev_busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q     <= '0;
            prev_trim_q <= trim_o;
            prev_busy_q <= 1'b0;
        end else begin
            prev_trim_q <= trim_o;
            prev_busy_q <= busy_o;
            if (trim_o != prev_trim_q || (busy_o && !prev_busy_q)) begin
                quiet_q <= '0;
            end else if (quiet_q != QMAX) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    AST_SETTLE_BEFORE_REQ: assert property (@(posedge clk) disable iff (rst)
        conv_req_o |-> (int'(quiet_q) + 1 >= SETTLE_CYC)); // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_req_o |=> !conv_req_o); // R2
    AST_REQ_WHILE_CAL: assert property (@(posedge clk) disable iff (rst)
        conv_req_o |-> cal_en_o); // R2
    AST_DIR_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        cal_en_o |=> !$rose(trim_o[6])); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o)); // R8
    AST_DONE_CAL_OFF: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !cal_en_o); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(trim_o)); // R8
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o); // R9

endmodule

bind amp_trim_cal amp_trim_cal_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cal_en_o   (cal_en_o),
    .conv_req_o (conv_req_o),
    .trim_o     (trim_o)
);

// File: tb/amp_trim_cal_tb.sv
module amp_trim_cal_tb;
    localparam int SETTLE = 16;
    localparam int RW     = 10;
    localparam int GAIN   = 30;
    localparam int N_VEC  = 11;
    localparam int OFF_TAB [N_VEC] = '{384, 383, -384, -385, 600, 390, 2000, 200, 1200, 2500, 900};
    localparam bit MODE_TAB[N_VEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic          conv_done_i = 1'b0;
    logic [RW-1:0] conv_data_i = '0;
    logic          busy_o, done_o, cal_en_o, conv_req_o;
    logic [6:0]    trim_o;

    int n_chk = 0;
    int n_bad = 0;
    int cur_off = 0;
    int conv_cnt = 0;
    int settle_bad = 0;
    int quiet = 0;
    int lat = 0;
    logic [6:0] last_trim = 7'h40;
    logic [6:0] req1_trim = '0;
    logic [6:0] req2_trim = '0;

    always #10 clk = ~clk;

    amp_trim_cal #(.SETTLE_CYC(SETTLE), .RES_W(RW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .busy_o(busy_o), .done_o(done_o), .cal_en_o(cal_en_o),
        .conv_req_o(conv_req_o), .trim_o(trim_o)
    );

    function automatic logic [RW-1:0] adc_model(input logic [6:0] t, input int off);
        int eff = t[6] ? int'(t[5:0]) : -int'(t[5:0]);
        int v = 512 + off - GAIN * eff;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return RW'(v);
    endfunction

    // 2 = high (top bits 111), 1 = low (000), 0 = mixed
    function automatic int judge(input logic [RW-1:0] r);
        if (r[RW-1:RW-3] == 3'b111) return 2;
        if (r[RW-1:RW-3] == 3'b000) return 1;
        return 0;
    endfunction

    task automatic ref_cal(input bit m, input int off, output logic [6:0] t, output int n);
        int c;
        t = m ? 7'h7F : 7'h40;
        n = 1;
        c = judge(adc_model(t, off));
        if (c == 0) return;
        if (c == 1) t[6] = 1'b0;
        for (int k = 5; k >= 0; k--) begin
            t[k] = !m;
            n++;
            c = judge(adc_model(t, off));
            if (c == 0) return;
            if (!((c == 2 && t[6]) || (c == 1 && !t[6]))) t[k] = m;
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ADC controller model and settle observer, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (trim_o !== last_trim) quiet = 0;
            else quiet++;
            last_trim = trim_o;
            if (conv_done_i) conv_done_i = 1'b0;
            if (conv_req_o) begin
                conv_cnt++;
                if (conv_cnt == 1) req1_trim = trim_o;
                if (conv_cnt == 2) req2_trim = trim_o;
                if (quiet < SETTLE) settle_bad++;
                lat = 3;
            end else if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    conv_data_i = adc_model(trim_o, cur_off);
                    conv_done_i = 1'b1;
                end
            end
        end
    end

    task automatic run_cal(input bit m, input int off, input bit poke, output logic [6:0] t, output int n);
        int cyc = 0;
        @(negedge clk);
        cur_off = off;
        conv_cnt = 0;
        settle_bad = 0;
        start_i = 1'b1;
        mode_i = m;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 30) begin
                start_i = 1'b1;
                mode_i = !m;
            end else begin
                start_i = 1'b0;
            end
        end
        check(cal_en_o == 1'b0, "R8 cal_en low with done", int'(cal_en_o), 0);
        t = trim_o;
        n = conv_cnt;
        check(settle_bad == 0, "R2 settle before request", settle_bad, 0);
        @(negedge clk);
        check(!done_o && !busy_o, "R8 done one cycle then idle", int'({done_o, busy_o}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] t, et;
        int n, en;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(trim_o == 7'h40, "R10 reset trim", int'(trim_o), 'h40);
        check({busy_o, done_o, cal_en_o, conv_req_o} == 4'b0, "R10 reset flags",
              int'({busy_o, done_o, cal_en_o, conv_req_o}), 0);

        // vector table: stimulus with reference-derived expectations (R5, R6, R7)
        for (int i = 0; i < N_VEC; i++) begin
            ref_cal(MODE_TAB[i], OFF_TAB[i], et, en);
            run_cal(MODE_TAB[i], OFF_TAB[i], 1'b0, t, n);
            check(t == et, "R6 final trim", int'(t), int'(et));
            check(n == en && n <= 7, "R7 conversion count", n, en);
            check(req1_trim == (MODE_TAB[i] ? 7'h7F : 7'h40), "R1 start code",
                  int'(req1_trim), MODE_TAB[i] ? 'h7F : 'h40);
        end

        // R3 classification edges and R4 first-measurement mixed
        run_cal(1'b0, 383, 1'b0, t, n);
        check(t == 7'h40 && n == 1, "R3 895 is mixed", int'({n[3:0], t}), 'h140);
        run_cal(1'b0, -384, 1'b0, t, n);
        check(t == 7'h40 && n == 1, "R3 128 is mixed", int'({n[3:0], t}), 'h140);

        // R4 low first result clears direction, R5 first pass writes bit 5
        run_cal(1'b0, -385, 1'b0, t, n);
        check(req2_trim == 7'h20, "R4 direction cleared then bit5 set", int'(req2_trim), 'h20);

        // R5 set-mode step on bit 5 then mixed
        run_cal(1'b0, 600, 1'b0, t, n);
        check(t == 7'h60 && n == 2, "R5 bit5 kept", int'({n[3:0], t}), 'h260);

        // R6 undo after overshoot: bit5 restored, bit4 set, then mixed
        run_cal(1'b0, 390, 1'b0, t, n);
        check(t == 7'h50 && n == 3, "R6 undo path", int'({n[3:0], t}), 'h350);

        // R6 continue path through bits 5, 4, 3
        run_cal(1'b0, 2000, 1'b0, t, n);
        check(t == 7'h78 && n == 4, "R6 continue path", int'({n[3:0], t}), 'h478);

        // R9 start and mode change during a run are ignored
        run_cal(1'b0, 2000, 1'b1, t, n);
        check(t == 7'h78 && n == 4, "R9 start ignored while busy", int'({n[3:0], t}), 'h478);

        // R8 trim held while idle, even with conversion traffic on the inputs
        conv_data_i = 10'h000;
        conv_done_i = 1'b1;
        repeat (20) @(negedge clk);
        conv_done_i = 1'b0;
        check(trim_o == 7'h78 && !busy_o, "R8 trim held after finish", int'(trim_o), 'h78);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule